// File: doc/BRIEF.md
# Latency Statistics Accumulator

This block times events marked by a start pulse and an end pulse, counting the clock cycles between them. Each time an event completes, it updates five running statistics: how many events completed, the sum of their latencies, the sum of their squared latencies, the shortest latency and the longest latency. From these numbers software derives the mean (sum divided by count) and the standard deviation (from count, sum and sum of squares). The division and the square root are done outside the block.

Only one event is timed at a time. Counting runs only while the enable input is high. A clear command restarts all statistics. A sample command copies all five live statistics into a snapshot on the same clock edge. Software reads the snapshot through a small indexed read port, so a read returns a set of values that belong together while the live values keep changing.

Top module: `lat_stats_acc`

## Requirements
- R1: An event starts on the edge where `start_i` is high and the block is idle. It ends on the edge where `end_i` is high, k edges later. Its latency is then k, so a start followed by an end one cycle later gives latency 1.
- R2: Each completed event adds one to the event count (index 0). The count wraps modulo 2^CNT_W.
- R3: Each completed event adds its latency to the latency sum (index 1). The sum is CNT_W bits wide and wraps modulo 2^CNT_W.
- R4: Each completed event adds the square of its latency to a sum of squares that is 2*CNT_W bits wide. The sum of squares is read as its low half (index 2) and its high half (index 3).
- R5: The minimum (index 4) and the maximum (index 5) track the shortest and longest latency seen. After reset or clear, the minimum is all ones and the maximum is zero.
- R6: A start pulse while an event is in progress is ignored. It does not restart the timing.
- R7: An end pulse with no event in progress is ignored. No statistic changes.
- R8: While `enable_i` is low, start pulses are ignored and any event in progress is dropped without being recorded.
- R9: A clear command takes priority over every other input. It zeroes the count and both sums, resets the minimum and maximum to their reset values, and aborts any event in progress.
- R10: A sample command copies all five live statistics into the snapshot on one edge. The copy holds the values from before that edge's update. The read port shows only the snapshot, so later events do not change what is read until the next sample. Indices 6 and 7 read as zero.
- R11: The latency counter saturates at all ones (2^CNT_W-1). An event longer than that is recorded with the saturated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Counting enable |
| clear_i | input | 1 | Clear all statistics and abort the event in progress |
| sample_i | input | 1 | Copy the live statistics into the snapshot |
| start_i | input | 1 | Event start pulse |
| end_i | input | 1 | Event end pulse |
| rd_idx_i | input | 3 | Read index into the snapshot |
| rd_data_o | output | CNT_W | Snapshot value selected by `rd_idx_i` |

## Verification
The assertions check the cycle-level rules on every cycle:
- the latency starts at 1 and then increments or saturates;
- the busy state holds against repeated starts;
- disable and clear abort the event in progress;
- the count changes only on a completed event;
- the snapshot copies the pre-edge count;
- the minimum never exceeds the maximum.

Only the bench's scenarios can show that the arithmetic is right: the exact sums, the squared terms landing in the correct half of the wide accumulator, wraparound of the narrow sum, and whether the reads stay isolated from events after a sample. To do this, the bench compares each read against its own behavioural model.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    SEL_COUNT = 3'd0,
    SEL_SUM   = 3'd1,
    SEL_SQ_LO = 3'd2,
    SEL_SQ_HI = 3'd3,
    SEL_MIN   = 3'd4,
    SEL_MAX   = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } rd_sel_e;
endpackage

// File: rtl/lat_evt_timer.sv
module lat_evt_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable_i,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic         end_i,
  output logic         busy_o,
  output logic [W-1:0] lat_o,
  output logic         done_o
);
  localparam logic [W-1:0] LAT_MAX = {W{1'b1}};
  localparam logic [W-1:0] LAT_ONE = W'(1);

  logic         busy_q;
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (clear_i || !enable_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (end_i) begin
        busy_q <= 1'b0;
      end else if (lat_q != LAT_MAX) begin
        lat_q <= lat_q + LAT_ONE;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      lat_q  <= LAT_ONE;
    end
  end

  assign busy_o = busy_q;
  assign lat_o  = lat_q;
  assign done_o = busy_q && end_i && enable_i && !clear_i;
endmodule

// File: rtl/lat_stat_acc.sv
module lat_stat_acc #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           done_i,
  input  logic [W-1:0]   lat_i,
  output logic [W-1:0]   count_o,
  output logic [W-1:0]   sum_o,
  output logic [2*W-1:0] sq_o,
  output logic [W-1:0]   min_o,
  output logic [W-1:0]   max_o
);
  localparam int            SQ_W    = 2 * W;
  localparam logic [W-1:0]  MIN_RST = {W{1'b1}};

  function automatic logic [SQ_W-1:0] f_square(input logic [W-1:0] v);
    logic [SQ_W-1:0] wide;
    wide = {{W{1'b0}}, v};
    return wide * wide;
  endfunction

  function automatic logic [W-1:0] f_lower(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] f_upper(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [W-1:0]    count_q, sum_q, min_q, max_q;
  logic [SQ_W-1:0] sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      count_q <= '0;
      sum_q   <= '0;
      sq_q    <= '0;
      min_q   <= MIN_RST;
      max_q   <= '0;
    end else if (done_i) begin
      count_q <= count_q + W'(1);
      sum_q   <= sum_q + lat_i;
      sq_q    <= sq_q + f_square(lat_i);
      min_q   <= f_lower(min_q, lat_i);
      max_q   <= f_upper(max_q, lat_i);
    end
  end

  assign count_o = count_q;
  assign sum_o   = sum_q;
  assign sq_o    = sq_q;
  assign min_o   = min_q;
  assign max_o   = max_q;
endmodule

// File: rtl/lat_snap_port.sv
module lat_snap_port
  import lat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [W-1:0]     count_i,
  input  logic [W-1:0]     sum_i,
  input  logic [2*W-1:0]   sq_i,
  input  logic [W-1:0]     min_i,
  input  logic [W-1:0]     max_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     snap_count_o,
  output logic [W-1:0]     data_o
);
  localparam int           SQ_W    = 2 * W;
  localparam logic [W-1:0] MIN_RST = {W{1'b1}};

  logic [W-1:0]    s_count, s_sum, s_min, s_max;
  logic [SQ_W-1:0] s_sq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_count <= '0;
      s_sum   <= '0;
      s_sq    <= '0;
      s_min   <= MIN_RST;
      s_max   <= '0;
    end else if (sample_i) begin
      s_count <= count_i;
      s_sum   <= sum_i;
      s_sq    <= sq_i;
      s_min   <= min_i;
      s_max   <= max_i;
    end
  end

  always_comb begin
    unique case (rd_sel_e'(idx_i))
      SEL_COUNT: data_o = s_count;
      SEL_SUM:   data_o = s_sum;
      SEL_SQ_LO: data_o = s_sq[W-1:0];
      SEL_SQ_HI: data_o = s_sq[SQ_W-1:W];
      SEL_MIN:   data_o = s_min;
      SEL_MAX:   data_o = s_max;
      default:   data_o = '0;
    endcase
  end

  assign snap_count_o = s_count;
endmodule

// File: rtl/lat_stats_acc.sv
module lat_stats_acc
  import lat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int SQ_W = 2 * CNT_W;

  logic             evt_busy;
  logic             evt_done;
  logic [CNT_W-1:0] evt_lat;
  logic [CNT_W-1:0] live_count, live_sum, live_min, live_max;
  logic [SQ_W-1:0]  live_sq;
  logic [CNT_W-1:0] snap_count;

  lat_evt_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .clear_i  (clear_i),
    .start_i  (start_i),
    .end_i    (end_i),
    .busy_o   (evt_busy),
    .lat_o    (evt_lat),
    .done_o   (evt_done)
  );

  lat_stat_acc #(.W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .done_i  (evt_done),
    .lat_i   (evt_lat),
    .count_o (live_count),
    .sum_o   (live_sum),
    .sq_o    (live_sq),
    .min_o   (live_min),
    .max_o   (live_max)
  );

  lat_snap_port #(.W(CNT_W)) u_snap (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .count_i      (live_count),
    .sum_i        (live_sum),
    .sq_i         (live_sq),
    .min_i        (live_min),
    .max_i        (live_max),
    .idx_i        (rd_idx_i),
    .snap_count_o (snap_count),
    .data_o       (rd_data_o)
  );
endmodule

// File: rtl/lat_stats_chk.sv
module lat_stats_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable_i,
  input logic         clear_i,
  input logic         sample_i,
  input logic         start_i,
  input logic         end_i,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] lat,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mn,
  input logic [W-1:0] mx,
  input logic [W-1:0] snap_cnt
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  p_first_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i && enable_i && !clear_i) |=> (busy && lat == W'(1)));

  p_lat_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_i && enable_i && !clear_i && lat != ALL1) |=> (lat == $past(lat) + W'(1)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == $past(cnt) + W'(1)));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !clear_i) |=> $stable(cnt));

  p_min_le_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (mn <= mx));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_i && enable_i && !clear_i) |=> busy);

  p_disable_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !busy);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt == '0 && mn == ALL1 && mx == '0 && !busy));

  p_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> (snap_cnt == $past(cnt)));

  p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat == ALL1 && !end_i && enable_i && !clear_i) |=> (lat == ALL1));
endmodule

bind lat_stats_acc lat_stats_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable_i (enable_i),
  .clear_i  (clear_i),
  .sample_i (sample_i),
  .start_i  (start_i),
  .end_i    (end_i),
  .busy     (evt_busy),
  .done     (evt_done),
  .lat      (evt_lat),
  .cnt      (live_count),
  .mn       (live_min),
  .mx       (live_max),
  .snap_cnt (snap_count)
);

// File: tb/tb_lat_stats_acc.sv
`timescale 1ns/1ps
module tb_lat_stats_acc;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int SQM  = (1 << (2 * W)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, clr = 1'b0, smp = 1'b0, st = 1'b0, nd = 1'b0;
  logic [2:0]   idx = 3'd0;
  logic [W-1:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  int last_rd = 0;
  int rot     = 0;

  // behavioural reference state
  int m_busy, m_lat, m_cnt, m_sum, m_sq, m_min, m_max;
  int s_cnt, s_sum, s_sq, s_min, s_max;

  always #4 clk = ~clk;

  lat_stats_acc #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .clear_i(clr), .sample_i(smp),
    .start_i(st), .end_i(nd), .rd_idx_i(idx), .rd_data_o(rd_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_lat = 0; m_cnt = 0; m_sum = 0; m_sq = 0; m_min = MASK; m_max = 0;
      s_cnt = 0; s_sum = 0; s_sq = 0; s_min = MASK; s_max = 0;
    end else begin
      if (smp) begin
        s_cnt = m_cnt; s_sum = m_sum; s_sq = m_sq; s_min = m_min; s_max = m_max;
      end
      if (clr) begin
        m_busy = 0; m_cnt = 0; m_sum = 0; m_sq = 0; m_min = MASK; m_max = 0;
      end else if (!en) begin
        m_busy = 0;
      end else if (m_busy != 0) begin
        if (nd) begin
          m_busy = 0;
          m_cnt = (m_cnt + 1) & MASK;
          m_sum = (m_sum + m_lat) & MASK;
          m_sq  = (m_sq + m_lat * m_lat) & SQM;
          if (m_lat < m_min) m_min = m_lat;
          if (m_lat > m_max) m_max = m_lat;
        end else if (m_lat < MASK) begin
          m_lat = m_lat + 1;
        end
      end else if (st) begin
        m_busy = 1; m_lat = 1;
      end
    end
  end

  function automatic int model_read(input int i);
    case (i)
      0: return s_cnt;
      1: return s_sum;
      2: return s_sq & MASK;
      3: return (s_sq >> W) & MASK;
      4: return s_min;
      5: return s_max;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic s, input logic e, input logic c, input logic p, input int i);
    int exp;
    st = s; nd = e; clr = c; smp = p; idx = 3'(i);
    #1;
    last_rd = int'(rd_data);
    exp = model_read(i);
    vectors++;
    if (last_rd != exp) begin
      errors++;
      $display("FAIL %s per-cycle read idx %0d: got %0d expected %0d", tag_of(i), i, last_rd, exp);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    rot = (rot + 1) % 8;
    step(0, 0, 0, 0, rot);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_event(input int k);
    step(1, 0, 0, 0, rot);
    for (int j = 0; j < k - 1; j++) idle();
    step(0, 1, 0, 0, rot);
  endtask

  task automatic sample_and_check(input string tag, input int c, input int s, input int ql,
                                  input int qh, input int mn, input int mx);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0); chk({tag, " R2 count"}, last_rd, c);
    step(0, 0, 0, 0, 1); chk({tag, " R3 sum"}, last_rd, s);
    step(0, 0, 0, 0, 2); chk({tag, " R4 sumsq low"}, last_rd, ql);
    step(0, 0, 0, 0, 3); chk({tag, " R4 sumsq high"}, last_rd, qh);
    step(0, 0, 0, 0, 4); chk({tag, " R5 min"}, last_rd, mn);
    step(0, 0, 0, 0, 5); chk({tag, " R5 max"}, last_rd, mx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state (R5, R10)
    sample_and_check("reset", 0, 0, 0, 0, 255, 0);
    step(0, 0, 0, 0, 6); chk("R10 reserved idx6", last_rd, 0);

    en = 1'b1;
    // R1: latencies 1 and 3; R6: repeated start ignored in a 5-cycle event
    run_event(1);
    run_event(3);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1);
    idle(); idle(); idle();
    step(0, 1, 0, 0, 2);
    // R7: end with nothing in progress
    step(0, 1, 0, 0, 3);
    sample_and_check("R1 R6 R7 basic", 3, 9, 35, 0, 1, 5);

    // R10: events after a sample do not show until the next sample
    run_event(2);
    step(0, 0, 0, 0, 0); chk("R10 isolation count", last_rd, 3);
    sample_and_check("R10 resample", 4, 11, 39, 0, 1, 5);

    // R8: start while disabled ignored, running event dropped by disable
    en = 1'b0;
    step(1, 0, 0, 0, 0);
    en = 1'b1;
    idle();
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    idle(); idle();
    en = 1'b0; idle();
    en = 1'b1;
    step(0, 1, 0, 0, 0);
    sample_and_check("R8 disable", 4, 11, 39, 0, 1, 5);

    // R9: clear aborts event and resets statistics
    step(1, 0, 0, 0, 0);
    idle();
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    sample_and_check("R9 clear", 0, 0, 0, 0, 255, 0);

    // R11: saturation at 255, then R3 sum wrap and R4 high half
    run_event(300);
    run_event(3);
    sample_and_check("R11 saturate", 2, 2, 10, 254, 3, 255);
    step(0, 0, 0, 0, 7); chk("R10 reserved idx7", last_rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule